// File: doc/BRIEF.md
# Serial Programming-Mode Entry Detector

This block sits on the target side of a serial programming port. It watches three pins: an enable level (a reset pin that doubles as the programming enable), a serial clock and a serial data line. It decides whether the device should enter its program/verify mode or start normally. Each pin first passes through its own synchronizer into the block clock domain.

A valid entry has three steps. The enable level must be asserted for any length of time and then released. While enable is low, a 32-bit key is clocked in, most significant bit first, one bit on each falling edge of the serial clock. Enable is then asserted again. The mode is entered only when exactly 32 bits were received and they equal the key. Any other path that ends with enable asserted selects the normal run path.

While the mode is active, the block asks for all unused I/O to be put in high impedance. After entry it holds off a data-valid flag for a set number of cycles, so that early line activity is not trusted. Dropping enable leaves the mode at once.

Top module: `pgm_entry_detect`

## Requirements
- R1: During and after reset, with enable low, mode_active, data_valid, io_hiz_req and run_mode are all 0.
- R2: When the synchronized enable rises and no valid key was collected, run_mode goes to 1 three clocks after the pin change and mode_active stays 0.
- R3: A key of 32'h4D434850 is accepted and mode_active goes to 1 when enable rises. The key is sent bit 31 first and bit 0 last, one bit per synchronized falling edge of the serial clock, after an enable pulse and release.
- R4: A 32-bit key that differs from 32'h4D434850 in any bit selects run_mode instead of mode_active.
- R5: Fewer than 32 bits, or more than 32 bits, clocked before enable rises select run_mode. This holds even when the last 32 bits equal the key.
- R6: Bits clocked while enable is high are discarded, and any partial key is cleared. A falling serial-clock edge in the same synchronized cycle that enable rises is not counted.
- R7: When enable falls while mode_active is 1, mode_active and io_hiz_req drop on the next clock after the synchronized fall.
- R8: data_valid is 0 for the first SETTLE_CYC clocks of mode_active. After that it is 1 for as long as mode_active stays 1.
- R9: io_hiz_req is 1 exactly when mode_active is 1.
- R10: Key bits clocked after reset but before the first enable pulse are ignored, so enable rising afterwards selects run_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pgm_en_async | input | 1 | Enable level from the pin, active high |
| ser_clk_async | input | 1 | Serial clock from the pin |
| ser_dat_async | input | 1 | Serial data from the pin |
| mode_active | output | 1 | Program/verify mode is active |
| data_valid | output | 1 | The settle interval has passed and line data may be trusted |
| io_hiz_req | output | 1 | Request to put unused I/O in high impedance |
| run_mode | output | 1 | Enable is asserted on the normal run path |

## Verification
Two events can land in the same synchronized cycle. The first is a falling edge of the serial clock that carries the last key bit. The second is the rise of enable that asks for a decision. The bench drives both pin changes on one clock edge after 31 good bits. The dropped bit leaves the count short, so the run path must win. A second collision is an enable drop in the same cycle that the settle interval ends. The behavioural reference model, checked on every clock, decides whether data_valid may rise there.

// File: rtl/pgm_entry_pkg.sv
package pgm_entry_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_LISTEN = 2'd2,
    ST_PROG   = 2'd3
  } entry_state_t;

  // Next-state rule of the entry sequencer.
  function automatic entry_state_t entry_next(entry_state_t cur, logic en, logic key_hit);
    entry_state_t nxt;
    nxt = cur;
    case (cur)
      ST_IDLE:   if (en)  nxt = ST_RUN;
      ST_RUN:    if (!en) nxt = ST_LISTEN;
      ST_LISTEN: if (en)  nxt = key_hit ? ST_PROG : ST_RUN;
      ST_PROG:   if (!en) nxt = ST_LISTEN;
      default:   nxt = ST_IDLE;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/pgm_sync.sv
module pgm_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0] chain [W];

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= '0;
        else        chain[i] <= {chain[i][STAGES-2:0], d[i]};
      end
      assign q[i] = chain[i][STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/pgm_key_shift.sv
module pgm_key_shift #(
  parameter int              KEY_W = 32,
  parameter logic [KEY_W-1:0] KEY  = 32'h4D434850
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic data_s,
  input  logic en_s,
  input  logic listen,
  output logic key_hit
);

  localparam int               CNT_W    = $clog2(KEY_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(KEY_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(KEY_W + 1);

  logic             sclk_q;
  logic             fall;
  logic [KEY_W-1:0] shreg;
  logic [CNT_W-1:0] cnt;

  assign fall = sclk_q & ~sclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      shreg  <= '0;
      cnt    <= '0;
    end else begin
      sclk_q <= sclk_s;
      if (en_s) begin
        shreg <= '0;
        cnt   <= '0;
      end else if (fall && listen) begin
        shreg <= {shreg[KEY_W-2:0], data_s};
        if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
      end
    end
  end

  assign key_hit = (cnt == CNT_FULL) && (shreg == KEY);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_OVER); // R5

  AST_NO_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!listen && !en_s) |=> $stable(cnt) || cnt == '0); // R10

endmodule

// File: rtl/pgm_entry_fsm.sv
module pgm_entry_fsm
  import pgm_entry_pkg::*;
#(
  parameter int SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_s,
  input  logic key_hit,
  output logic listen,
  output logic mode_active,
  output logic run_mode,
  output logic data_valid
);

  localparam int               SET_W    = $clog2(SETTLE_CYC + 1);
  localparam logic [SET_W-1:0] SET_DONE = SET_W'(SETTLE_CYC);

  entry_state_t     state;
  logic [SET_W-1:0] settle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      settle <= '0;
    end else begin
      state <= entry_next(state, en_s, key_hit);
      if (state != ST_PROG)       settle <= '0;
      else if (settle != SET_DONE) settle <= settle + 1'b1;
    end
  end

  assign listen      = (state == ST_LISTEN);
  assign mode_active = (state == ST_PROG);
  assign run_mode    = (state == ST_RUN);
  assign data_valid  = mode_active && (settle == SET_DONE);

  AST_EXIT_PROMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_active && !en_s) |=> !mode_active); // R7

  AST_VALID_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> mode_active); // R8

  AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && en_s) |=> data_valid); // R8

endmodule

// File: rtl/pgm_entry_detect.sv
module pgm_entry_detect #(
  parameter int               KEY_W       = 32,
  parameter logic [KEY_W-1:0] KEY         = 32'h4D434850,
  parameter int               SETTLE_CYC  = 16,
  parameter int               SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pgm_en_async,
  input  logic ser_clk_async,
  input  logic ser_dat_async,
  output logic mode_active,
  output logic data_valid,
  output logic io_hiz_req,
  output logic run_mode
);

  logic [2:0] pins_s;
  logic       en_s;
  logic       sclk_s;
  logic       data_s;
  logic       key_hit;
  logic       listen;

  pgm_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({pgm_en_async, ser_clk_async, ser_dat_async}),
    .q     (pins_s)
  );

  assign {en_s, sclk_s, data_s} = pins_s;

  pgm_key_shift #(.KEY_W(KEY_W), .KEY(KEY)) u_key (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_s  (sclk_s),
    .data_s  (data_s),
    .en_s    (en_s),
    .listen  (listen),
    .key_hit (key_hit)
  );

  pgm_entry_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_s        (en_s),
    .key_hit     (key_hit),
    .listen      (listen),
    .mode_active (mode_active),
    .run_mode    (run_mode),
    .data_valid  (data_valid)
  );

  assign io_hiz_req = mode_active;

  AST_KEY_TO_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(en_s) && key_hit) |=> mode_active); // R3

  AST_MODE_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_active) |-> $past(key_hit)); // R4

  AST_RUN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_mode && mode_active)); // R2

endmodule

// File: tb/pgm_entry_detect_test.sv
module pgm_entry_detect_test;

  localparam int          SET = 16;
  localparam logic [31:0] KEY = 32'h4D434850;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, sck = 1'b0, sd = 1'b0;
  logic mode_active, data_valid, io_hiz_req, run_mode;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  pgm_entry_detect #(.SETTLE_CYC(SET)) uut (
    .clk(clk), .rst_n(rst_n),
    .pgm_en_async(en), .ser_clk_async(sck), .ser_dat_async(sd),
    .mode_active(mode_active), .data_valid(data_valid),
    .io_hiz_req(io_hiz_req), .run_mode(run_mode)
  );

  // Behavioural reference: pin history queues, integer state
  // (0 idle, 1 run, 2 listening for key, 3 program mode).
  int qe[$], qs[$], qd[$];
  logic [31:0] mk;
  int mcnt, mst, mset;

  always @(posedge clk) begin
    if (!rst_n) begin
      qe = {0, 0, 0, 0}; qs = {0, 0, 0, 0}; qd = {0, 0, 0, 0};
      mk = '0; mcnt = 0; mst = 0; mset = 0;
    end else begin
      int n, e, f, d, ps;
      bit ok;
      qe.push_back(int'(en)); qs.push_back(int'(sck)); qd.push_back(int'(sd));
      n  = qe.size();
      e  = qe[n-3];
      f  = (qs[n-4] == 1 && qs[n-3] == 0) ? 1 : 0;
      d  = qd[n-3];
      ps = mst;
      ok = (mcnt == 32) && (mk == KEY);
      if (ps == 0 && e == 1)      mst = 1;
      else if (ps == 1 && e == 0) mst = 2;
      else if (ps == 2 && e == 1) mst = ok ? 3 : 1;
      else if (ps == 3 && e == 0) mst = 2;
      if (ps != 3) mset = 0;
      else if (mset < SET) mset++;
      if (e == 1) begin mk = '0; mcnt = 0; end
      else if (f == 1 && ps == 2) begin
        mk = {mk[30:0], d[0]};
        if (mcnt < 33) mcnt++;
      end
      void'(qe.pop_front()); void'(qs.pop_front()); void'(qd.pop_front());
    end
  end

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Compare against the model on every clock, away from the edge.
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R3 mode_active vs model", mode_active, mst == 3);
      chk("R2 run_mode vs model",    run_mode,    mst == 1);
      chk("R8 data_valid vs model",  data_valid,  (mst == 3) && (mset == SET));
      chk("R9 io_hiz_req vs model",  io_hiz_req,  mst == 3);
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_n(int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    sd = b; sck = 1'b1; wait_n(3);
    sck = 1'b0;         wait_n(3);
  endtask

  task automatic send_bits(logic [63:0] v, int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic pulse_release();
    en = 1'b1; wait_n(5);
    en = 1'b0; wait_n(5);
  endtask

  initial begin
    wait_n(5);
    chk("R1 mode_active in reset", mode_active, 1'b0);
    chk("R1 run_mode in reset",    run_mode,    1'b0);
    rst_n = 1'b1;
    wait_n(3);
    chk("R1 data_valid after reset", data_valid, 1'b0);
    chk("R1 io_hiz_req after reset", io_hiz_req, 1'b0);

    // R10: key before any enable pulse is ignored
    send_bits({32'h0, KEY}, 32);
    en = 1'b1; wait_n(6);
    chk("R10 run after unpulsed key", run_mode, 1'b1);
    chk("R10 no mode",                mode_active, 1'b0);
    en = 1'b0; wait_n(5);

    // R3 / R8 / R9 / R7: good key
    send_bits({32'h0, KEY}, 32);
    en = 1'b1; wait_n(6);
    chk("R3 mode entered", mode_active, 1'b1);
    chk("R8 not yet valid", data_valid, 1'b0);
    chk("R9 hiz requested", io_hiz_req, 1'b1);
    wait_n(SET + 2);
    chk("R8 valid after settle", data_valid, 1'b1);
    en = 1'b0; wait_n(4);
    chk("R7 mode exited", mode_active, 1'b0);
    chk("R7 hiz released", io_hiz_req, 1'b0);

    // R2: reassert with no key
    en = 1'b1; wait_n(6);
    chk("R2 run without key", run_mode, 1'b1);
    en = 1'b0; wait_n(5);

    // R4: one bit wrong
    send_bits({32'h0, KEY ^ 32'h0000_0100}, 32);
    en = 1'b1; wait_n(6);
    chk("R4 wrong key -> run", run_mode, 1'b1);
    chk("R4 wrong key no mode", mode_active, 1'b0);
    en = 1'b0; wait_n(5);

    // R5: too few bits
    send_bits({32'h0, KEY} >> 1, 31);
    en = 1'b1; wait_n(6);
    chk("R5 short key -> run", run_mode, 1'b1);
    en = 1'b0; wait_n(5);

    // R5: 33 bits whose last 32 match
    send_bits({31'h0, 1'b0, KEY}, 33);
    en = 1'b1; wait_n(6);
    chk("R5 long key -> run", run_mode, 1'b1);
    chk("R5 long key no mode", mode_active, 1'b0);
    en = 1'b0; wait_n(5);

    // R6: partial key, then pulse clears it, then full key enters
    send_bits({32'h0, KEY} >> 16, 16);
    send_bit(1'b1);
    en = 1'b1; send_bit(1'b0); send_bit(1'b1);
    en = 1'b0; wait_n(5);
    send_bits({32'h0, KEY}, 32);
    en = 1'b1; wait_n(6);
    chk("R6 cleared partial, mode entered", mode_active, 1'b1);

    // R8 collision: drop enable exactly as settle ends
    en = 1'b0; wait_n(5);
    send_bits({32'h0, KEY}, 32);
    en = 1'b1; wait_n(SET + 1);
    en = 1'b0; wait_n(6);
    chk("R7 exit at settle boundary", mode_active, 1'b0);

    // R6 collision: last falling edge lands with enable rise
    send_bits({32'h0, KEY} >> 1, 31);
    sd = KEY[0]; sck = 1'b1; wait_n(3);
    sck = 1'b0; en = 1'b1; wait_n(6);
    chk("R6 same-cycle bit dropped -> run", run_mode, 1'b1);
    chk("R6 same-cycle no mode", mode_active, 1'b0);
    en = 1'b0; wait_n(6);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule